// File: doc/BRIEF.md
# Multiplexed External Bus Read Sequencer

This block runs read accesses on an external bus whose address pins are shared with status over time. It is clocked at twice the bus rate. A toggle register makes the bus clock, so each bus cycle is one clock in the high phase and then one clock in the low phase. In the high phase the shared 23-bit pin group carries the address. In the low phase the same pins carry three fields: a 3-bit access code, a 4-bit queue status that lags by one access, and 16 bits of visibility data from the last access that completed.

The internal side offers a request with a ready/valid handshake. The request carries an address, an access code, a queue status, visibility data for internal reads, an internal/external select and a length of 1 to MAX_LEN bus cycles. The sequencer holds the address steady across every cycle of an access. In the stretch cycles it drives neutral zero status. For an external read it opens a window in the last low phase, during which the outside device may drive the data bus. The block samples the bus at the end of that window and returns the word as a one-clock response. A new request can be taken in the last low phase of the running access, so accesses can run back to back with no idle cycle between them.

Top module: `mxb_read_seq`

## Requirements
- R1: `bus_clk_o` inverts on every clock after reset. Reset leaves it low, and the first phase after reset is high. A bus cycle is one high phase followed by one low phase.
- R2: In a high phase, `addr_o` equals the request address on every cycle of that access. In an idle cycle it is zero.
- R3: In the low phase of the first cycle of an access, `addr_o[22:20]` is that access's code. It is 000 in stretch cycles and in idle cycles.
- R4: In the low phase of a first cycle or an idle cycle, `addr_o[19:16]` shows the queue status of the access accepted before. In stretch cycles it is 0000.
- R5: In the low phase of a first cycle or an idle cycle, `addr_o[15:0]` shows the visibility data of the last completed access. For an external read this is the captured bus word. For an internal read it is the request's `req_ivd_i`. In stretch cycles it is zero.
- R6: `dbus_win_o` is high only in the low phase of the final cycle of an external read. It is never high for an internal read.
- R7: `data_i` is sampled at the end of that window. In the following clock, `rsp_valid_o` is high for exactly one clock and `rsp_data_o` holds the sampled word. An internal read gives no response.
- R8: `rw_o` is high (read) at all times.
- R9: An access lasts `req_len_i` bus cycles. A length of 0 is treated as 1.
- R10: `req_ready_o` is high only in a low phase, and only when the sequencer is idle or in the final cycle of an access. A request held while ready is low is not taken, and the current address stays on the pins. An accepted request starts in the very next phase.
- R11: Synchronous reset returns the sequencer to idle. It closes the window, keeps `rw_o` high and clears the stored status and visibility data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at the next edge |
| req_addr_i | input | 23 | Access address |
| req_acc_i | input | 3 | Access code |
| req_iqs_i | input | 4 | Queue status of this access |
| req_ivd_i | input | 16 | Visibility data for an internal read |
| req_ext_i | input | 1 | 1 = external read, 0 = internal read |
| req_len_i | input | 4 | Length in bus cycles (0 treated as 1) |
| rsp_valid_o | output | 1 | External read data returned |
| rsp_data_o | output | 16 | Returned read data |
| bus_clk_o | output | 1 | Bus clock, high = address phase |
| addr_o | output | 23 | Multiplexed address/status pins |
| rw_o | output | 1 | Read/write strobe, 1 = read |
| data_i | input | 16 | Data bus sampled from the pins |
| dbus_win_o | output | 1 | Data bus released to the external device |

## Verification
Two things can happen in the same clock edge. The final low phase of one access samples its bus word or fixes its visibility data, and the next request is accepted. The new access's first low phase must then show the word captured at that same edge, not an older one. The bench provokes this by presenting each next request early and keeping it valid through the stretch cycles. The handshake then releases it exactly at the final low phase. The bench checks that the pins show the just-completed access's status and data on the first low phase that follows, and that the response pulse of an external read lines up with the new access's first high phase.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int ADDR_W  = 23;
    localparam int ACC_W   = 3;
    localparam int IQS_W   = 4;
    localparam int DATA_W  = 16;
    localparam int MAX_LEN = 8;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    // Low-phase word layout: code on top, queue status, then visibility data
    localparam int LOW_W = ACC_W + IQS_W + DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ACC_W-1:0]  acc;
        logic [IQS_W-1:0]  iqs;
        logic [DATA_W-1:0] ivd;
        logic              ext;
        logic [LEN_W-1:0]  len;
    } rd_req_t;

    typedef struct packed {
        logic              active;
        logic              stretch;
        rd_req_t           cur;
        logic [IQS_W-1:0]  iqs_show;
        logic [DATA_W-1:0] ivd_show;
    } seq_view_t;

    function automatic logic [LEN_W-1:0] norm_len(input logic [LEN_W-1:0] l);
        return (l == '0) ? LEN_W'(1) : l;
    endfunction

    function automatic logic [LOW_W-1:0] pack_low(input logic [ACC_W-1:0] a,
                                                  input logic [IQS_W-1:0] q,
                                                  input logic [DATA_W-1:0] d);
        return {a, q, d};
    endfunction

endpackage

// File: rtl/mxb_phase.sv
module mxb_phase (
    input  logic clk,
    input  logic rst,
    output logic hi_q
);
    always_ff @(posedge clk) begin
        if (rst) hi_q <= 1'b0;
        else     hi_q <= ~hi_q;
    end
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_q,
    input  logic              req_valid,
    input  rd_req_t           req,
    input  logic [DATA_W-1:0] bus_data,
    output logic              req_ready,
    output logic              win,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output seq_view_t         view
);
    logic              active_q, stretch_q;
    rd_req_t           cur_q;
    logic [LEN_W-1:0]  cyc_q;
    logic [IQS_W-1:0]  last_iqs_q, iqs_show_q;
    logic [DATA_W-1:0] last_ivd_q, ivd_show_q;

    logic              cyc_start, last_cyc, accept, finishing;
    logic [DATA_W-1:0] fin_ivd, nxt_ivd;

    always_comb begin
        cyc_start = ~hi_q;
        last_cyc  = active_q && (cyc_q == LEN_W'(cur_q.len - LEN_W'(1)));
        req_ready = cyc_start && (~active_q || last_cyc);
        accept    = req_ready && req_valid;
        finishing = cyc_start && last_cyc;
        fin_ivd   = cur_q.ext ? bus_data : cur_q.ivd;
        nxt_ivd   = finishing ? fin_ivd : last_ivd_q;
        win       = ~hi_q && last_cyc && cur_q.ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            stretch_q  <= 1'b0;
            cur_q      <= '0;
            cyc_q      <= '0;
            last_iqs_q <= '0;
            iqs_show_q <= '0;
            last_ivd_q <= '0;
            ivd_show_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (cyc_start) begin
                if (finishing) begin
                    last_ivd_q <= fin_ivd;
                    if (cur_q.ext) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= bus_data;
                    end
                end
                if (accept) begin
                    active_q   <= 1'b1;
                    stretch_q  <= 1'b0;
                    cur_q      <= req;
                    cur_q.len  <= norm_len(req.len);
                    cyc_q      <= '0;
                    iqs_show_q <= last_iqs_q;
                    ivd_show_q <= nxt_ivd;
                    last_iqs_q <= req.iqs;
                end else if (active_q && !last_cyc) begin
                    cyc_q     <= cyc_q + LEN_W'(1);
                    stretch_q <= 1'b1;
                end else begin
                    active_q   <= 1'b0;
                    stretch_q  <= 1'b0;
                    iqs_show_q <= last_iqs_q;
                    ivd_show_q <= nxt_ivd;
                end
            end
        end
    end

    always_comb begin
        view.active   = active_q;
        view.stretch  = stretch_q;
        view.cur      = cur_q;
        view.iqs_show = iqs_show_q;
        view.ivd_show = ivd_show_q;
    end
endmodule

// File: rtl/mxb_pinmux.sv
module mxb_pinmux
    import mxb_pkg::*;
(
    input  logic              hi_q,
    input  seq_view_t         view,
    output logic [ADDR_W-1:0] pins
);
    logic [ACC_W-1:0] code;

    always_comb begin
        code = view.active ? view.cur.acc : '0;
        if (hi_q) begin
            pins = view.active ? view.cur.addr : '0;
        end else if (view.stretch) begin
            pins = '0;
        end else begin
            pins = ADDR_W'(pack_low(code, view.iqs_show, view.ivd_show));
        end
    end
endmodule

// File: rtl/mxb_read_seq.sv
module mxb_read_seq
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ACC_W-1:0]  req_acc_i,
    input  logic [IQS_W-1:0]  req_iqs_i,
    input  logic [DATA_W-1:0] req_ivd_i,
    input  logic              req_ext_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              bus_clk_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    input  logic [DATA_W-1:0] data_i,
    output logic              dbus_win_o
);
    logic      hi_q;
    rd_req_t   req;
    seq_view_t view;
    logic      stretch_w;

    always_comb begin
        req.addr = req_addr_i;
        req.acc  = req_acc_i;
        req.iqs  = req_iqs_i;
        req.ivd  = req_ivd_i;
        req.ext  = req_ext_i;
        req.len  = req_len_i;
    end

    mxb_phase u_phase (.clk(clk), .rst(rst), .hi_q(hi_q));

    mxb_seq u_seq (
        .clk(clk), .rst(rst), .hi_q(hi_q),
        .req_valid(req_valid_i), .req(req), .bus_data(data_i),
        .req_ready(req_ready_o), .win(dbus_win_o),
        .rsp_valid(rsp_valid_o), .rsp_data(rsp_data_o), .view(view)
    );

    mxb_pinmux u_mux (.hi_q(hi_q), .view(view), .pins(addr_o));

    assign stretch_w = view.stretch;
    assign bus_clk_o = hi_q;
    assign rw_o      = 1'b1;
endmodule

// File: rtl/mxb_read_seq_chk.sv
module mxb_read_seq_chk
    import mxb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_clk_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              req_ready_o,
    input logic              dbus_win_o,
    input logic              rsp_valid_o,
    input logic              stretch
);
    p_clk_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bus_clk_o != $past(bus_clk_o)));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_clk_o && stretch) |-> (addr_o == $past(addr_o, 2)));

    p_win_low_r6: assert property (@(posedge clk) disable iff (rst)
        bus_clk_o |-> !dbus_win_o);

    p_win_single_r6: assert property (@(posedge clk) disable iff (rst)
        dbus_win_o |=> !dbus_win_o);

    p_rsp_follows_win_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> $past(dbus_win_o));

    p_ready_low_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> !bus_clk_o);
endmodule

bind mxb_read_seq mxb_read_seq_chk u_chk (
    .clk(clk), .rst(rst), .bus_clk_o(bus_clk_o), .addr_o(addr_o),
    .req_ready_o(req_ready_o), .dbus_win_o(dbus_win_o),
    .rsp_valid_o(rsp_valid_o), .stretch(stretch_w)
);

// File: tb/mxb_read_seq_tb.sv
module mxb_read_seq_tb_top;
    import mxb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ACC_W-1:0]  req_acc = '0;
    logic [IQS_W-1:0]  req_iqs = '0;
    logic [DATA_W-1:0] req_ivd = '0;
    logic              req_ext = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              bus_clk;
    logic [ADDR_W-1:0] addr_pins;
    logic              rw;
    logic [DATA_W-1:0] data_bus = '0;
    logic              win;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4ns clk = ~clk;

    mxb_read_seq dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_acc_i(req_acc), .req_iqs_i(req_iqs),
        .req_ivd_i(req_ivd), .req_ext_i(req_ext), .req_len_i(req_len),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .bus_clk_o(bus_clk),
        .addr_o(addr_pins), .rw_o(rw), .data_i(data_bus), .dbus_win_o(win)
    );

    // {addr, acc, iqs, ivd, ext, len, bus data}
    localparam int VW = 67;
    localparam int NV = 7;
    localparam logic [VW-1:0] VEC [NV] = '{
        {23'h123456, 3'd5, 4'hA, 16'h1111, 1'b1, 4'd1, 16'hBEEF},
        {23'h7F0F0F, 3'd2, 4'h3, 16'h2222, 1'b0, 4'd2, 16'h0000},
        {23'h400001, 3'd7, 4'hC, 16'h3333, 1'b1, 4'd4, 16'hC0DE},
        {23'h00ABCD, 3'd1, 4'h5, 16'h4444, 1'b0, 4'd1, 16'h0000},
        {23'h555555, 3'd6, 4'hF, 16'h5555, 1'b1, 4'd0, 16'hA5A5},
        {23'h2AAAAA, 3'd3, 4'h9, 16'h6666, 1'b1, 4'd8, 16'h5A5A},
        {23'h010203, 3'd4, 4'h6, 16'h7777, 1'b0, 4'd4, 16'h0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(input int k);
        logic [VW-1:0] v;
        v = VEC[k];
        req_addr = v[66:44];
        req_acc  = v[43:41];
        req_iqs  = v[40:37];
        req_ivd  = v[36:21];
        req_ext  = v[20];
        req_len  = v[19:16];
        req_valid = 1'b1;
    endtask

    initial begin
        logic [IQS_W-1:0]  prev_iqs;
        logic [DATA_W-1:0] prev_ivd;
        bit                prev_ext;
        logic [DATA_W-1:0] prev_dat;
        prev_iqs = '0; prev_ivd = '0; prev_ext = 0; prev_dat = '0;

        repeat (3) @(negedge clk);
        // R11 / R1 / R8: reset state
        chk(bus_clk == 1'b0, "R1 reset phase", 32'(bus_clk), 0);
        chk(addr_pins == '0, "R11 reset pins", 32'(addr_pins), 0);
        chk(win == 1'b0 && rsp_valid == 1'b0, "R11 reset window", 32'({win, rsp_valid}), 0);
        chk(rw == 1'b1, "R8 reset strobe", 32'(rw), 1);

        rst = 1'b0;
        load(0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            int L;
            v = VEC[i];
            L = (v[19:16] == 0) ? 1 : int'(v[19:16]);
            for (int c = 0; c < L; c++) begin
                @(negedge clk); // high phase
                chk(bus_clk == 1'b1, "R1 high phase", 32'(bus_clk), 1);
                chk(addr_pins == v[66:44], "R2 address held", 32'(addr_pins), 32'(v[66:44]));
                chk(rw == 1'b1, "R8 strobe", 32'(rw), 1);
                chk(req_ready == 1'b0, "R10 ready in high", 32'(req_ready), 0);
                if (c == 0) begin
                    req_valid = 1'b0;
                    if (i > 0) begin
                        chk(rsp_valid == prev_ext, "R7 response valid", 32'(rsp_valid), 32'(prev_ext));
                        if (prev_ext)
                            chk(rsp_data == prev_dat, "R7 response data", 32'(rsp_data), 32'(prev_dat));
                    end
                end else begin
                    chk(rsp_valid == 1'b0, "R7 no extra response", 32'(rsp_valid), 0);
                end
                @(negedge clk); // low phase
                chk(bus_clk == 1'b0, "R1 low phase", 32'(bus_clk), 0);
                if (c == 0) begin
                    chk(addr_pins[22:20] == v[43:41], "R3 access code", 32'(addr_pins[22:20]), 32'(v[43:41]));
                    chk(addr_pins[19:16] == prev_iqs, "R4 lagged status", 32'(addr_pins[19:16]), 32'(prev_iqs));
                    chk(addr_pins[15:0] == prev_ivd, "R5 visibility data", 32'(addr_pins[15:0]), 32'(prev_ivd));
                    if (i + 1 < NV) load(i + 1);
                end else begin
                    chk(addr_pins == '0, "R3 R4 R5 stretch neutral", 32'(addr_pins), 0);
                end
                chk(req_ready == (c == L - 1), "R10 ready only in final cycle", 32'(req_ready), 32'(c == L - 1));
                chk(win == (v[20] && c == L - 1), "R6 data window R9 length", 32'(win), 32'(v[20] && c == L - 1));
                if (c == L - 1) data_bus = v[20] ? v[15:0] : 16'hDEAD;
            end
            prev_iqs = v[40:37];
            prev_ivd = v[20] ? v[15:0] : v[36:21];
            prev_ext = v[20];
            prev_dat = v[15:0];
        end

        // idle after the last access
        @(negedge clk);
        chk(addr_pins == '0, "R2 idle address", 32'(addr_pins), 0);
        chk(rsp_valid == prev_ext, "R7 last response", 32'(rsp_valid), 32'(prev_ext));
        @(negedge clk);
        chk(addr_pins == {3'b000, prev_iqs, prev_ivd}, "R4 R5 idle status",
            32'(addr_pins), 32'({3'b000, prev_iqs, prev_ivd}));
        chk(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 1);

        // reset in the middle of a stretched external access
        load(2);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(addr_pins == '0 && win == 1'b0, "R11 reset mid access", 32'({win, addr_pins}), 0);
        chk(rw == 1'b1, "R11 strobe in reset", 32'(rw), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_clk == 1'b1 && addr_pins == '0, "R1 R11 first phase after reset",
            32'({bus_clk, addr_pins}), 32'h0080_0000);
        @(negedge clk);
        chk(addr_pins == '0, "R11 stored status cleared", 32'(addr_pins), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule